// File: doc/BRIEF.md
# Programmable Overflow Timer with Power-of-Two Prescaler

This block is a free-running up-counter that works either as an 8-bit or a 16-bit timer. It counts ticks from the system clock or from an external input, on a chosen edge. An optional prescaler can sit in front of the counter and divide the tick rate by a power of two. When the counter wraps, it raises a sticky overflow flag. The flag, gated by an enable input, drives an interrupt request.

Software reaches the block through a small register port. A write strobe carries an address and a data byte, and an independent read address returns a byte combinationally. The control byte sets how the timer runs. Two byte-wide count registers expose the counter. A flag register lets software clear the overflow flag. The prescaler count itself is never visible. Software changes it only indirectly, because a write to either count register clears it while the prescaler is in use.

Top module: `prog_timer`

## Requirements
- R1: After reset, the control register, both count bytes and the overflow flag read 0, and `irq` is 0.
- R2: Register map by address: 0 is control, 1 is the count low byte, 2 is the count high byte, and 3 is the flag register with the flag in bit 0. The control bits are: bit 7 run, bit 6 narrow (8-bit) mode, bit 5 external source, bit 4 falling edge, bit 3 prescaler bypass, and bits 2:0 the ratio. Control reads back what was written.
- R3: With bypass = 1 and the internal source selected, the count advances by one on every clock while run = 1.
- R4: With bypass = 0, a ratio value n gives one count advance per 2^(n+1) source ticks. For example, n = 1 divides by 4 and n = 7 divides by 256.
- R5: While bypass = 0, a write to address 1 or 2 clears the hidden prescaler count and leaves the control register unchanged. A count write always takes priority over an advance in the same cycle.
- R6: In narrow mode, only the low byte counts. The flag sets when the low byte wraps from FFh to 00h, and the high byte holds its value.
- R7: In 16-bit mode, the flag sets only when the whole count wraps from FFFFh to 0000h. A wrap of the low byte alone does not set it.
- R8: Writing 0 to bit 0 of address 3 clears the flag. Writing 1 there has no effect. If an overflow and a clear happen in the same cycle, the flag ends up set.
- R9: `irq` equals the overflow flag ANDed with `irq_en`.
- R10: While run = 0, the count and the prescaler hold their values, and no overflow occurs.
- R11: With the external source bit set to 1, `ext_in` passes through a two-flop synchronizer. One tick is produced per rising edge when the edge bit is 0, and per falling edge when it is 1. The opposite edge produces no tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_in | input | 1 | Asynchronous external count input |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Combinational read data |
| irq_en | input | 1 | Interrupt enable |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a clear of the flag that lands in exactly the cycle the counter wraps. The bench preloads the low byte to FEh in narrow bypass mode, starts the timer, and waits one clock. It then issues the clear so that it commits on the wrap edge. The hidden prescaler clear is also hard to observe, because the prescaler cannot be read. To expose it, the bench writes the count in the middle of a divide-by-4 period and checks that the next advance comes a full four ticks later rather than one tick later.

// File: rtl/tmr_pkg.sv
// Package: shared types and register addresses for the overflow timer.
// Assumes: the control byte layout below is the one software programs.
package tmr_pkg;

    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 2;
    localparam int RATIO_W = 3;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_CNTL = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_CNTH = 2'd2;
    localparam logic [ADDR_W-1:0] ADDR_FLAG = 2'd3;

    // Control byte, bit 7 down to bit 0.
    typedef struct packed {
        logic               run;
        logic               narrow;
        logic               ext_src;
        logic               fall_edge;
        logic               bypass;
        logic [RATIO_W-1:0] ratio;
    } tmr_ctrl_t;

endpackage

// File: rtl/tmr_tick_src.sv
// Module: tmr_tick_src
// Produces one source tick per cycle: every clock for the internal source,
// or a one-cycle pulse per selected edge of the synchronized external input.
// Assumes: SYNC_STAGES >= 2; ext_in is asynchronous to clk.
module tmr_tick_src #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_in,
    input  logic ext_src,
    input  logic fall_edge,
    output logic tick
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;
    logic                   rise_p;
    logic                   fall_p;
    logic                   ext_tick;

    // Synchronizer chain, one flop per stage.
    genvar s;
    generate
        for (s = 0; s < SYNC_STAGES; s++) begin : g_sync
            if (s == 0) begin : g_first
                // First stage captures the raw input.
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[0] <= 1'b0;
                    else        sync_q[0] <= ext_in;
                end
            end else begin : g_next
                // Later stages shift the value along.
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[s] <= 1'b0;
                    else        sync_q[s] <= sync_q[s-1];
                end
            end
        end
    endgenerate

    // Previous synchronized level, used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= sync_q[SYNC_STAGES-1];
    end

    // Edge pulses and source selection.
    always_comb begin
        rise_p   = sync_q[SYNC_STAGES-1] & ~last_q;
        fall_p   = ~sync_q[SYNC_STAGES-1] & last_q;
        ext_tick = fall_edge ? fall_p : rise_p;
        tick     = ext_src ? ext_tick : 1'b1;
    end

    // Edge pulses of one polarity cannot occur in consecutive cycles.
    assert_edge_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rise_p |=> !rise_p);
    assert_fall_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        fall_p |=> !fall_p);

endmodule

// File: rtl/tmr_prescaler.sv
// Module: tmr_prescaler
// Hidden power-of-two divider in front of the counter. Ratio n divides the
// source ticks by 2^(n+1). In bypass, every source tick advances the count.
// Assumes: clr is asserted only while the divider is assigned.
module tmr_prescaler #(
    parameter int PRE_W   = 8,
    parameter int RATIO_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               bypass,
    input  logic [RATIO_W-1:0] ratio,
    input  logic               tick,
    input  logic               clr,
    output logic               adv
);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] mask;
    logic             full;
    logic             step;

    // Mask of the low (ratio+1) bits that must roll over.
    always_comb begin
        for (int i = 0; i < PRE_W; i++) mask[i] = (i <= int'(ratio));
        full = &(pre_q | ~mask);
        step = run & tick;
        adv  = step & (bypass | full);
    end

    // Divider count: clear on count write, else step when assigned.
    always_ff @(posedge clk) begin
        if (!rst_n)                pre_q <= '0;
        else if (clr)              pre_q <= '0;
        else if (step && !bypass)  pre_q <= pre_q + 1'b1;
    end

    assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> pre_q == '0);
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clr) |=> $stable(pre_q));
    assert_rollover_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !bypass && !clr) |=> (pre_q & $past(mask)) == '0);

endmodule

// File: rtl/tmr_counter.sv
// Module: tmr_counter
// The visible count with byte-wide loads and 8/16-bit overflow detection.
// Assumes: a byte load in a cycle suppresses that cycle's advance.
module tmr_counter #(
    parameter int CNT_W  = 16,
    parameter int LOW_W  = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              narrow,
    input  logic              adv,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [DATA_W-1:0] wr_byte,
    output logic [CNT_W-1:0]  count,
    output logic              ovf
);

    localparam int HIGH_W = CNT_W - LOW_W;

    logic [LOW_W-1:0]  lo_q;
    logic [HIGH_W-1:0] hi_q;
    logic              load;
    logic              do_adv;

    // Advance only when no byte load is pending; overflow point by mode.
    always_comb begin
        load   = wr_lo | wr_hi;
        do_adv = adv & ~load;
        ovf    = do_adv & (narrow ? (&lo_q) : (&{hi_q, lo_q}));
        count  = {hi_q, lo_q};
    end

    // Low byte: load, or count in either mode.
    always_ff @(posedge clk) begin
        if (!rst_n)      lo_q <= '0;
        else if (wr_lo)  lo_q <= wr_byte[LOW_W-1:0];
        else if (do_adv) lo_q <= lo_q + 1'b1;
    end

    // High byte: load, or carry from the low byte in 16-bit mode only.
    always_ff @(posedge clk) begin
        if (!rst_n)                            hi_q <= '0;
        else if (wr_hi)                        hi_q <= wr_byte[HIGH_W-1:0];
        else if (do_adv && !narrow && (&lo_q)) hi_q <= hi_q + 1'b1;
    end

    assert_wrap8_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && narrow) |=> (count[LOW_W-1:0] == '0) && $stable(count[CNT_W-1:LOW_W]));
    assert_wrap16_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !narrow) |=> count == '0);
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !load) |=> $stable(count));

endmodule

// File: rtl/prog_timer.sv
// Module: prog_timer (top)
// Register decode, control register, sticky overflow flag and interrupt
// request around the tick source, prescaler and counter.
// Assumes: register reads are combinational; writes commit on the clock edge.
module prog_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int LOW_W       = 8,
    parameter int PRE_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              irq_en,
    output logic              ovf_flag,
    output logic              irq
);

    tmr_ctrl_t        ctrl_q;
    logic             flag_q;
    logic             wr_ctrl;
    logic             wr_lo;
    logic             wr_hi;
    logic             flag_clr;
    logic             pre_clr;
    logic             tick;
    logic             adv;
    logic             ovf;
    logic [CNT_W-1:0] count;

    // Write decode.
    always_comb begin
        wr_ctrl  = wr_en && (wr_addr == ADDR_CTRL);
        wr_lo    = wr_en && (wr_addr == ADDR_CNTL);
        wr_hi    = wr_en && (wr_addr == ADDR_CNTH);
        flag_clr = wr_en && (wr_addr == ADDR_FLAG) && !wr_data[0];
        pre_clr  = (wr_lo || wr_hi) && !ctrl_q.bypass;
    end

    // Control register.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= tmr_ctrl_t'(wr_data);
    end

    // Sticky flag: overflow sets and wins over a software clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        flag_q <= 1'b0;
        else if (ovf)      flag_q <= 1'b1;
        else if (flag_clr) flag_q <= 1'b0;
    end

    tmr_tick_src #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_in    (ext_in),
        .ext_src   (ctrl_q.ext_src),
        .fall_edge (ctrl_q.fall_edge),
        .tick      (tick)
    );

    tmr_prescaler #(
        .PRE_W   (PRE_W),
        .RATIO_W (RATIO_W)
    ) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (ctrl_q.run),
        .bypass (ctrl_q.bypass),
        .ratio  (ctrl_q.ratio),
        .tick   (tick),
        .clr    (pre_clr),
        .adv    (adv)
    );

    tmr_counter #(
        .CNT_W  (CNT_W),
        .LOW_W  (LOW_W),
        .DATA_W (DATA_W)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .narrow  (ctrl_q.narrow),
        .adv     (adv),
        .wr_lo   (wr_lo),
        .wr_hi   (wr_hi),
        .wr_byte (wr_data),
        .count   (count),
        .ovf     (ovf)
    );

    // Read mux and outputs.
    always_comb begin
        case (rd_addr)
            ADDR_CTRL: rd_data = ctrl_q;
            ADDR_CNTL: rd_data = DATA_W'(count[LOW_W-1:0]);
            ADDR_CNTH: rd_data = DATA_W'(count[CNT_W-1:LOW_W]);
            default:   rd_data = DATA_W'(flag_q);
        endcase
        ovf_flag = flag_q;
        irq      = flag_q & irq_en;
    end

    assert_ovf_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf_flag);
    assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !flag_clr) |=> ovf_flag);
    assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ovf_flag && irq_en));
    assert_ctrl_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo || wr_hi) |=> $stable(ctrl_q));
    assert_no_ovf_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q.run |-> !ovf);

endmodule

// File: tb/sim_prog_timer.sv
// Scoreboard bench: driver tasks queue expected items, a monitor compares.
module sim_prog_timer;

    localparam int CLK_P    = 10;
    localparam int WATCHDOG = 200000;

    localparam int SRC_OVF = 4;
    localparam int SRC_IRQ = 5;

    typedef struct {
        int         src;
        logic [7:0] exp;
        string      tag;
    } sb_item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_in = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       irq_en = 1'b0;
    logic       ovf_flag;
    logic       irq;

    sb_item_t sb_q[$];
    int       n_run = 0;
    int       n_fail = 0;
    bit       done = 1'b0;

    prog_timer u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_in   (ext_in),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .irq_en   (irq_en),
        .ovf_flag (ovf_flag),
        .irq      (irq)
    );

    always #(CLK_P/2) clk = ~clk;

    // Monitor: compares every queued item a quarter period after the falling edge.
    always begin
        @(negedge clk);
        #(CLK_P/4);
        while (sb_q.size() > 0) begin
            sb_item_t it;
            logic [7:0] act;
            it = sb_q.pop_front();
            if (it.src == SRC_OVF)      act = {7'd0, ovf_flag};
            else if (it.src == SRC_IRQ) act = {7'd0, irq};
            else                        act = rd_data;
            n_run++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s: actual %02h expected %02h", it.tag, act, it.exp);
            end
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Called at a falling edge; the write commits on the next rising edge.
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic exp_rd(input logic [1:0] a, input logic [7:0] e, input string tag);
        rd_addr = a;
        sb_q.push_back('{src: int'(a), exp: e, tag: tag});
    endtask

    task automatic exp_pin(input int src, input logic e, input string tag);
        sb_q.push_back('{src: src, exp: {7'd0, e}, tag: tag});
    endtask

    initial begin
        idle(4);
        rst_n = 1'b1;
        // R1: reset state
        exp_rd(2'd0, 8'h00, "R1 ctrl"); exp_pin(SRC_OVF, 1'b0, "R1 flag"); exp_pin(SRC_IRQ, 1'b0, "R1 irq");
        idle(1); exp_rd(2'd1, 8'h00, "R1 count lo");
        idle(1); exp_rd(2'd2, 8'h00, "R1 count hi");
        idle(1); exp_rd(2'd3, 8'h00, "R1 flag reg");

        // R3/R7: bypass, internal, 16-bit, from FFF0h
        idle(1); wr(2'd1, 8'hF0); wr(2'd2, 8'hFF);
        wr(2'd0, 8'h88);
        exp_rd(2'd0, 8'h88, "R2 ctrl readback");
        idle(5); exp_rd(2'd1, 8'hF5, "R3 count per clock");
        idle(1); exp_rd(2'd2, 8'hFF, "R7 hi before wrap");
        idle(11);
        exp_rd(2'd1, 8'h01, "R7 count after wrap");
        exp_pin(SRC_OVF, 1'b1, "R7 flag on FFFF wrap");
        exp_pin(SRC_IRQ, 1'b0, "R9 masked irq");
        wr(2'd0, 8'h08);
        irq_en = 1'b1;
        exp_pin(SRC_IRQ, 1'b1, "R9 enabled irq");
        exp_rd(2'd1, 8'h02, "R10 count at stop");
        idle(3); exp_rd(2'd1, 8'h02, "R10 count holds");
        idle(1); wr(2'd3, 8'h01);
        exp_rd(2'd3, 8'h01, "R8 write 1 no effect");
        wr(2'd3, 8'h00);
        exp_rd(2'd3, 8'h00, "R8 clear by write 0");
        exp_pin(SRC_IRQ, 1'b0, "R9 irq after clear");

        // R6/R8: narrow mode wrap with same-cycle clear
        wr(2'd1, 8'hFE);
        wr(2'd0, 8'hC8);
        idle(1); exp_rd(2'd1, 8'hFF, "R6 low before wrap");
        wr(2'd3, 8'h00);
        exp_pin(SRC_OVF, 1'b1, "R8 overflow wins over clear");
        exp_pin(SRC_IRQ, 1'b1, "R9 irq on narrow wrap");
        exp_rd(2'd2, 8'h00, "R6 high byte holds");
        idle(1); exp_rd(2'd1, 8'h01, "R6 low after wrap");
        wr(2'd0, 8'h48);
        wr(2'd3, 8'h00);
        exp_pin(SRC_OVF, 1'b0, "R8 flag cleared");

        // R7: 16-bit low-byte wrap does not flag
        wr(2'd1, 8'hFE); wr(2'd2, 8'h00);
        wr(2'd0, 8'h88);
        idle(3); exp_rd(2'd2, 8'h01, "R7 carry into hi");
        exp_pin(SRC_OVF, 1'b0, "R7 no flag on low wrap");

        // R4/R5: divide by 4 and prescaler clear on count write
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h00); wr(2'd2, 8'h00);
        wr(2'd0, 8'h81);
        idle(8); exp_rd(2'd1, 8'h02, "R4 div4 count");
        idle(2); wr(2'd1, 8'h10);
        idle(3); exp_rd(2'd1, 8'h10, "R5 prescaler cleared");
        idle(1); exp_rd(2'd1, 8'h11, "R5 advance after full period");
        idle(1); exp_rd(2'd0, 8'h81, "R5 control unchanged");

        // R4: divide by 256
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h00); wr(2'd2, 8'h00);
        wr(2'd0, 8'h87);
        idle(255); exp_rd(2'd1, 8'h00, "R4 div256 before");
        idle(1);   exp_rd(2'd1, 8'h01, "R4 div256 after");

        // R11: external source, falling then rising edge
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h00);
        wr(2'd0, 8'hB8);
        ext_in = 1'b1; idle(6); exp_rd(2'd1, 8'h00, "R11 rise ignored in falling mode");
        ext_in = 1'b0; idle(6); exp_rd(2'd1, 8'h01, "R11 falling edge counts");
        wr(2'd0, 8'hA8);
        ext_in = 1'b1; idle(6); exp_rd(2'd1, 8'h02, "R11 rising edge counts");
        ext_in = 1'b0; idle(6); exp_rd(2'd1, 8'h02, "R11 fall ignored in rising mode");

        idle(2);
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule